// File: doc/BRIEF.md
# Dual-Channel Raster Timing Generator

This block produces raster timing for a configurable number of display channels (two by default, called main and auxiliary). Each channel walks a pixel counter through the four phases of a line and a line counter through the four phases of a frame. From these counters it drives horizontal sync, vertical sync, data-enable and the pixel column and row inside the visible window. Each channel sets a frame-start status bit, and the channels share a masked interrupt line.

Software programs the block through a single-cycle write port. Each timing field is written as its count minus one into a staged copy. A commit write arms the transfer of the staged copy into the working copy, and the transfer happens at the next frame boundary, so a mode change never tears a frame. The enable bit and the interrupt mask act at once. The status bits are readable on a port and are cleared by writing ones.

Register map, with C as the channel number and word address 8*C + offset: offset 0 is the visible size, with width-1 in bits [11:0] and height-1 in bits [23:12]. Offset 1 is horizontal timing and offset 2 is vertical timing, each with sync-1 in [11:0], back porch-1 in [23:12] and front porch-1 in [35:24]. Offset 3 is control: bit 0 enables the channel, bit 1 makes hsync active-low, and bit 2 makes vsync active-low. Offset 4 is commit, and writing a 1 to bit 0 arms it. Address 8*NCH is the shared status register, with bit C for channel C. Address 8*NCH+1 is the shared mask register, with bit C for channel C.

Top module: `dual_raster_timer`

## Requirements
- R1: After reset every channel is disabled, all status and mask bits are 0, hsync, vsync and de are 0, pix_x and pix_y are 0, and the working timing fields are all 0, so every phase lasts one count.
- R2: On an enabled channel, a line of (S+1)+(B+1)+(A+1)+(F+1) clocks starts with S+1 clocks of hsync asserted, where S, B, A and F are the horizontal sync, back porch, active width and front porch fields. Those sync clocks are followed by back porch, active and front porch in that order. The first enabled clock is the first clock of a line.
- R3: The vertical counter advances once per line through vsync (vsync field+1 lines), back porch, active (height field+1 lines) and front porch, and then wraps to frame start.
- R4: de is 1 only when both the horizontal and vertical phases are active. pix_x and pix_y count from 0 at the first visible pixel and line, and both are 0 whenever de is 0.
- R5: Control bit 1 inverts hsync and control bit 2 inverts vsync, so the sync is driven low while asserted. Both bits are staged settings.
- R6: A disabled channel holds de at 0 and holds its syncs at the inactive level (which equals the polarity bit). Its counters restart from frame start when it is enabled again.
- R7: Writes to the size, timing and polarity settings change no output until a commit is written. The staged values then take effect at the next frame start, or on the next clock if the channel is disabled.
- R8: A channel's status bit is set one clock after the channel is at the first clock of its vertical sync phase, whatever the mask.
- R9: Writing the status address clears each bit written as 1 and leaves bits written as 0 unchanged. A new frame-start event in the same clock wins over the clear.
- R10: irq is the OR over channels of status AND mask, and it follows both without an added register.
- R11: Channels are independent: one channel's settings, enable and commit do not change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word address |
| wr_data | input | 3*FW | Register write data |
| int_status | output | NCH | Frame-start status bits, one per channel |
| irq | output | 1 | Combined masked interrupt |
| hsync | output | NCH | Horizontal sync per channel, polarity applied |
| vsync | output | NCH | Vertical sync per channel, polarity applied |
| de | output | NCH | Data-enable per channel |
| pix_x | output | NCH*FW | Visible column per channel, FW bits each |
| pix_y | output | NCH*FW | Visible row per channel, FW bits each |

## Verification
hsync, vsync, de, pix_x and pix_y are decoded from the counter registers, so they are due in the cycle the counters hold a position. The first enabled cycle, the one right after the enabling write's edge, already shows the start of sync. A status bit appears one edge after the frame-start position, irq appears in that same cycle, and a committed mode shows from the first cycle of the next frame. The bench keeps a cycle model of counters, staged and working settings, and status. It compares every output against that model at each falling edge, between the edge that updated the design and the next one.

// File: rtl/drt_pkg.sv
`timescale 1ns/1ps
package drt_pkg;
   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } drt_phase_e;

   localparam int CH_SPAN    = 8;
   localparam int OFS_SIZE   = 0;
   localparam int OFS_HTIM   = 1;
   localparam int OFS_VTIM   = 2;
   localparam int OFS_CTRL   = 3;
   localparam int OFS_COMMIT = 4;
endpackage

// File: rtl/drt_axis.sv
`timescale 1ns/1ps
module drt_axis
   import drt_pkg::*;
#(
   parameter int FW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   input  logic [FW-1:0] f_sync,
   input  logic [FW-1:0] f_back,
   input  logic [FW-1:0] f_act,
   input  logic [FW-1:0] f_front,
   output drt_phase_e    phase,
   output logic          last,
   output logic          at_zero,
   output logic [FW-1:0] pos
);
   localparam int CW = FW + 2;

   logic [CW-1:0] cnt, e_sync, e_back, e_act, e_tot;

   always_comb begin
      e_sync = CW'(f_sync) + CW'(1);
      e_back = e_sync + CW'(f_back) + CW'(1);
      e_act  = e_back + CW'(f_act) + CW'(1);
      e_tot  = e_act + CW'(f_front) + CW'(1);
   end

   assign last    = (cnt == e_tot - CW'(1));
   assign at_zero = (cnt == '0);

   always_comb begin
      if (cnt < e_sync)      phase = PH_SYNC;
      else if (cnt < e_back) phase = PH_BACK;
      else if (cnt < e_act)  phase = PH_ACT;
      else                   phase = PH_FRONT;
   end

   logic [CW-1:0] rel;
   assign rel = cnt - e_back;
   assign pos = (phase == PH_ACT) ? rel[FW-1:0] : '0;

   logic [1:0] unused_rel_top;
   assign unused_rel_top = rel[CW-1:FW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (adv)   cnt <= last ? '0 : cnt + CW'(1);
   end
endmodule

// File: rtl/drt_cfg.sv
`timescale 1ns/1ps
module drt_cfg
   import drt_pkg::*;
#(
   parameter int FW = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sel,
   input  logic [2:0]      wr_ofs,
   input  logic [3*FW-1:0] wr_data,
   input  logic            frame_wrap,
   output logic            en,
   output logic            hpol,
   output logic            vpol,
   output logic [2*FW-1:0] act_size,
   output logic [3*FW-1:0] act_htim,
   output logic [3*FW-1:0] act_vtim
);
   logic [2*FW-1:0] stg_size;
   logic [3*FW-1:0] stg_htim, stg_vtim;
   logic [1:0]      stg_pol;
   logic            pend;
   logic            apply;

   assign apply = pend && (frame_wrap || !en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_size <= '0;
         stg_htim <= '0;
         stg_vtim <= '0;
         stg_pol  <= '0;
         act_size <= '0;
         act_htim <= '0;
         act_vtim <= '0;
         hpol     <= 1'b0;
         vpol     <= 1'b0;
         en       <= 1'b0;
         pend     <= 1'b0;
      end else begin
         if (apply) begin
            act_size <= stg_size;
            act_htim <= stg_htim;
            act_vtim <= stg_vtim;
            hpol     <= stg_pol[0];
            vpol     <= stg_pol[1];
            pend     <= 1'b0;
         end
         if (sel) begin
            case (int'(wr_ofs))
               OFS_SIZE:   stg_size <= wr_data[2*FW-1:0];
               OFS_HTIM:   stg_htim <= wr_data;
               OFS_VTIM:   stg_vtim <= wr_data;
               OFS_CTRL: begin
                  en      <= wr_data[0];
                  stg_pol <= wr_data[2:1];
               end
               OFS_COMMIT: if (wr_data[0]) pend <= 1'b1;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/drt_chan.sv
`timescale 1ns/1ps
module drt_chan
   import drt_pkg::*;
#(
   parameter int FW = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sel,
   input  logic [2:0]      wr_ofs,
   input  logic [3*FW-1:0] wr_data,
   output logic            hsync,
   output logic            vsync,
   output logic            de,
   output logic [FW-1:0]   pix_x,
   output logic [FW-1:0]   pix_y,
   output logic            frame_set,
   output logic            en,
   output logic            hpol
);
   logic            vpol;
   logic [2*FW-1:0] act_size;
   logic [3*FW-1:0] act_htim, act_vtim;
   logic            frame_wrap;
   drt_phase_e      hph, vph;
   logic            h_last, v_last, h_zero, v_zero;
   logic [FW-1:0]   hpos, vpos;

   drt_cfg #(.FW(FW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_ofs(wr_ofs), .wr_data(wr_data),
      .frame_wrap(frame_wrap), .en(en), .hpol(hpol), .vpol(vpol),
      .act_size(act_size), .act_htim(act_htim), .act_vtim(act_vtim)
   );

   drt_axis #(.FW(FW)) u_h (
      .clk(clk), .rst_n(rst_n), .clr(!en), .adv(en),
      .f_sync(act_htim[FW-1:0]), .f_back(act_htim[2*FW-1:FW]),
      .f_act(act_size[FW-1:0]), .f_front(act_htim[3*FW-1:2*FW]),
      .phase(hph), .last(h_last), .at_zero(h_zero), .pos(hpos)
   );

   drt_axis #(.FW(FW)) u_v (
      .clk(clk), .rst_n(rst_n), .clr(!en), .adv(en && h_last),
      .f_sync(act_vtim[FW-1:0]), .f_back(act_vtim[2*FW-1:FW]),
      .f_act(act_size[2*FW-1:FW]), .f_front(act_vtim[3*FW-1:2*FW]),
      .phase(vph), .last(v_last), .at_zero(v_zero), .pos(vpos)
   );

   assign frame_wrap = en && h_last && v_last;
   assign frame_set  = en && h_zero && v_zero;

   assign hsync = (en && (hph == PH_SYNC)) ^ hpol;
   assign vsync = (en && (vph == PH_SYNC)) ^ vpol;
   assign de    = en && (hph == PH_ACT) && (vph == PH_ACT);
   assign pix_x = de ? hpos : '0;
   assign pix_y = de ? vpos : '0;
endmodule

// File: rtl/dual_raster_timer.sv
`timescale 1ns/1ps
module dual_raster_timer
   import drt_pkg::*;
#(
   parameter int NCH = 2,
   parameter int FW  = 12,
   parameter int AW  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [3*FW-1:0]   wr_data,
   output logic [NCH-1:0]    int_status,
   output logic              irq,
   output logic [NCH-1:0]    hsync,
   output logic [NCH-1:0]    vsync,
   output logic [NCH-1:0]    de,
   output logic [NCH*FW-1:0] pix_x,
   output logic [NCH*FW-1:0] pix_y
);
   localparam int ST_ADDR   = NCH * CH_SPAN;
   localparam int MASK_ADDR = ST_ADDR + 1;

   if (NCH < 1) begin : g_bad_nch
      $error("dual_raster_timer: NCH must be at least 1");
   end
   if (FW < 3) begin : g_bad_fw
      $error("dual_raster_timer: FW must be at least 3");
   end
   if (AW < 3 || (1 << AW) < MASK_ADDR + 1) begin : g_bad_aw
      $error("dual_raster_timer: AW too small for the register map");
   end
   if (3 * FW < NCH) begin : g_bad_dw
      $error("dual_raster_timer: data word narrower than channel count");
   end

   logic [NCH-1:0] irq_mask, frame_set, chan_en, hpol_act, clr_vec;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel;
      assign sel = wr_en && (int'(wr_addr) < ST_ADDR) &&
                   ((int'(wr_addr) / CH_SPAN) == c);

      drt_chan #(.FW(FW)) u_chan (
         .clk(clk), .rst_n(rst_n), .sel(sel), .wr_ofs(wr_addr[2:0]),
         .wr_data(wr_data),
         .hsync(hsync[c]), .vsync(vsync[c]), .de(de[c]),
         .pix_x(pix_x[c*FW +: FW]), .pix_y(pix_y[c*FW +: FW]),
         .frame_set(frame_set[c]), .en(chan_en[c]), .hpol(hpol_act[c])
      );
   end

   assign clr_vec = (wr_en && int'(wr_addr) == ST_ADDR) ? wr_data[NCH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_status <= '0;
         irq_mask   <= '0;
      end else begin
         int_status <= (int_status & ~clr_vec) | frame_set;
         if (wr_en && int'(wr_addr) == MASK_ADDR) irq_mask <= wr_data[NCH-1:0];
      end
   end

   assign irq = |(int_status & irq_mask);
endmodule

// File: rtl/drt_checker.sv
`timescale 1ns/1ps
module drt_checker #(
   parameter int NCH = 2,
   parameter int FW  = 12,
   parameter int AW  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [AW-1:0]     wr_addr,
   input logic [3*FW-1:0]   wr_data,
   input logic [NCH-1:0]    int_status,
   input logic              irq,
   input logic [NCH-1:0]    hsync,
   input logic [NCH-1:0]    de,
   input logic [NCH*FW-1:0] pix_x,
   input logic [NCH-1:0]    frame_set,
   input logic [NCH-1:0]    chan_en,
   input logic [NCH-1:0]    hpol_act
);
   localparam int ST_ADDR = NCH * 8;

   logic st_wr;
   assign st_wr = wr_en && (int'(wr_addr) == ST_ADDR);

   for (genvar c = 0; c < NCH; c++) begin : g_chk
      a_r8_status_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
         frame_set[c] |=> int_status[c]);

      a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (st_wr && wr_data[c] && !frame_set[c]) |=> !int_status[c]);

      a_r9_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (int_status[c] && !(st_wr && wr_data[c])) |=> int_status[c]);

      a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
         de[c] |-> (hsync[c] == hpol_act[c]));

      a_r4_x_steps: assert property (@(posedge clk) disable iff (!rst_n)
         (de[c] && $past(de[c])) |->
            (pix_x[c*FW +: FW] == $past(pix_x[c*FW +: FW]) + FW'(1)));

      a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !chan_en[c] |-> (!de[c] && (hsync[c] == hpol_act[c])));
   end

   a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (int_status != '0));
endmodule

bind dual_raster_timer drt_checker #(.NCH(NCH), .FW(FW), .AW(AW)) u_drt_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .int_status(int_status), .irq(irq), .hsync(hsync), .de(de), .pix_x(pix_x),
   .frame_set(frame_set), .chan_en(chan_en), .hpol_act(hpol_act)
);

// File: tb/dual_raster_timer_bench.sv
`timescale 1ns/1ps
module dual_raster_timer_bench;
   localparam int NCH = 2;
   localparam int FW  = 12;
   localparam int AW  = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [3*FW-1:0]   wr_data = '0;
   logic [NCH-1:0]    int_status, hsync, vsync, de;
   logic              irq;
   logic [NCH*FW-1:0] pix_x, pix_y;

   dual_raster_timer #(.NCH(NCH), .FW(FW), .AW(AW)) u_dual_raster_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .int_status(int_status), .irq(irq), .hsync(hsync), .vsync(vsync), .de(de),
      .pix_x(pix_x), .pix_y(pix_y)
   );

   always #2.5 clk = ~clk;

   int    n_chk = 0;
   int    n_err = 0;
   bit    done = 0;
   string cur_req = "R1";

   // model: fields 0 hs,1 hb,2 width,3 hf,4 vs,5 vb,6 height,7 vf
   int m_f [NCH][8];
   int m_s [NCH][8];
   bit m_en [NCH], m_pend [NCH], m_ph [NCH], m_pv [NCH];
   bit m_sph [NCH], m_spv [NCH], m_st [NCH], m_mask [NCH];
   int m_hc [NCH], m_vc [NCH];

   task automatic chk(input string req, input string what, input int ch,
                      input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s ch%0d during %s: got %0d expected %0d",
                  req, what, ch, cur_req, act, exp);
      end
   endtask

   function automatic int ph_of(int cnt, int s, int b, int a);
      if (cnt < s + 1) return 0;
      if (cnt < s + b + 2) return 1;
      if (cnt < s + b + a + 3) return 2;
      return 3;
   endfunction

   task automatic compare_all();
      int exp_irq = 0;
      for (int c = 0; c < NCH; c++) begin
         int hph = ph_of(m_hc[c], m_f[c][0], m_f[c][1], m_f[c][2]);
         int vph = ph_of(m_vc[c], m_f[c][4], m_f[c][5], m_f[c][6]);
         int e_hs = int'((m_en[c] && hph == 0) ^ m_ph[c]);
         int e_vs = int'((m_en[c] && vph == 0) ^ m_pv[c]);
         int e_de = int'(m_en[c] && hph == 2 && vph == 2);
         int e_x  = e_de ? m_hc[c] - (m_f[c][0] + m_f[c][1] + 2) : 0;
         int e_y  = e_de ? m_vc[c] - (m_f[c][4] + m_f[c][5] + 2) : 0;
         chk("R2", "hsync", c, int'(hsync[c]), e_hs);
         chk("R3", "vsync", c, int'(vsync[c]), e_vs);
         chk("R4", "de", c, int'(de[c]), e_de);
         chk("R4", "pix_x", c, int'(pix_x[c*FW +: FW]), e_x);
         chk("R4", "pix_y", c, int'(pix_y[c*FW +: FW]), e_y);
         chk("R8", "status", c, int'(int_status[c]), int'(m_st[c]));
         if (m_st[c] && m_mask[c]) exp_irq = 1;
      end
      chk("R10", "irq", 0, int'(irq), exp_irq);
   endtask

   task automatic model_next(input logic we, input logic [AW-1:0] a,
                             input logic [3*FW-1:0] d);
      for (int c = 0; c < NCH; c++) begin
         int ht = m_f[c][0] + m_f[c][1] + m_f[c][2] + m_f[c][3] + 4;
         int vt = m_f[c][4] + m_f[c][5] + m_f[c][6] + m_f[c][7] + 4;
         bit hl = (m_hc[c] == ht - 1);
         bit vl = (m_vc[c] == vt - 1);
         bit wrap = m_en[c] && hl && vl;
         bit fset = m_en[c] && m_hc[c] == 0 && m_vc[c] == 0;
         int nhc = 0, nvc = 0;
         bit clr;
         if (m_en[c]) begin
            if (hl) begin nhc = 0; nvc = vl ? 0 : m_vc[c] + 1; end
            else begin nhc = m_hc[c] + 1; nvc = m_vc[c]; end
         end
         if (m_pend[c] && (wrap || !m_en[c])) begin
            for (int k = 0; k < 8; k++) m_f[c][k] = m_s[c][k];
            m_ph[c] = m_sph[c];
            m_pv[c] = m_spv[c];
            m_pend[c] = 0;
         end
         clr = we && int'(a) == NCH * 8 && d[c];
         m_st[c] = (m_st[c] && !clr) || fset;
         if (we && int'(a) < NCH * 8 && int'(a) / 8 == c) begin
            case (int'(a) % 8)
               0: begin m_s[c][2] = int'(d[11:0]); m_s[c][6] = int'(d[23:12]); end
               1: begin m_s[c][0] = int'(d[11:0]); m_s[c][1] = int'(d[23:12]);
                        m_s[c][3] = int'(d[35:24]); end
               2: begin m_s[c][4] = int'(d[11:0]); m_s[c][5] = int'(d[23:12]);
                        m_s[c][7] = int'(d[35:24]); end
               3: begin m_en[c] = d[0]; m_sph[c] = d[1]; m_spv[c] = d[2]; end
               4: if (d[0]) m_pend[c] = 1;
               default: ;
            endcase
         end
         m_hc[c] = nhc;
         m_vc[c] = nvc;
      end
      if (we && int'(a) == NCH * 8 + 1)
         for (int c = 0; c < NCH; c++) m_mask[c] = d[c];
   endtask

   task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [3*FW-1:0] d);
      compare_all();
      wr_en = we; wr_addr = a; wr_data = d;
      model_next(we, a, d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, '0, '0);
   endtask

   task automatic wr(input int a, input logic [3*FW-1:0] d);
      cyc(1'b1, AW'(a), d);
   endtask

   function automatic logic [3*FW-1:0] tim(int s, int b, int f);
      return {12'(f), 12'(b), 12'(s)};
   endfunction

   function automatic logic [3*FW-1:0] sz(int w, int h);
      return {12'd0, 12'(h), 12'(w)};
   endfunction

   task automatic rnd_chan(input int c, input bit pol);
      wr(c*8 + 0, sz($urandom_range(0, 9), $urandom_range(0, 5)));
      wr(c*8 + 1, tim($urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 2)));
      wr(c*8 + 2, tim($urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 2)));
      wr(c*8 + 3, {33'd0, pol & 1'($urandom_range(0, 1)),
                   pol & 1'($urandom_range(0, 1)), 1'b1});
      wr(c*8 + 4, 36'd1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < NCH; c++) begin
         for (int k = 0; k < 8; k++) begin m_f[c][k] = 0; m_s[c][k] = 0; end
         m_en[c] = 0; m_pend[c] = 0; m_ph[c] = 0; m_pv[c] = 0; m_sph[c] = 0;
         m_spv[c] = 0; m_st[c] = 0; m_mask[c] = 0; m_hc[c] = 0; m_vc[c] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      cur_req = "R1";
      chk("R1", "hsync after reset", 0, int'(hsync), 0);
      chk("R1", "vsync after reset", 0, int'(vsync), 0);
      chk("R1", "de after reset", 0, int'(de), 0);
      chk("R1", "status after reset", 0, int'(int_status), 0);
      chk("R1", "irq after reset", 0, int'(irq), 0);
      chk("R1", "pix after reset", 0, int'(pix_x | pix_y), 0);
      idle(20);

      cur_req = "R2";
      wr(0, sz(5, 3));
      wr(1, tim(1, 2, 1));
      wr(2, tim(0, 1, 0));
      wr(4, 36'd1);
      wr(17, 36'd1);
      wr(3, 36'd1);
      idle(600);

      cur_req = "R7";
      wr(1, tim(3, 0, 2));
      wr(0, sz(2, 1));
      idle(300);
      wr(4, 36'd1);
      idle(600);

      cur_req = "R5";
      wr(3, 36'h7);
      wr(4, 36'd1);
      idle(500);

      cur_req = "R9";
      wr(16, 36'd0);
      idle(2);
      wr(16, 36'h3);
      idle(2);
      wr(16, 36'h1);
      idle(100);

      cur_req = "R6";
      wr(3, 36'h6);
      idle(60);
      chk("R6", "de while disabled", 0, int'(de[0]), 0);
      chk("R6", "hsync idle level", 0, int'(hsync[0]), 1);
      wr(3, 36'h7);
      idle(200);

      cur_req = "R11";
      for (int r = 0; r < 6; r++) begin
         rnd_chan(1, 1'b1);
         idle(int'($urandom_range(100, 700)));
         rnd_chan(0, 1'b1);
         wr(17, 36'($urandom_range(0, 3)));
         idle(int'($urandom_range(600, 1200)));
         if ($urandom_range(0, 1) == 1) wr(16, 36'($urandom_range(0, 3)));
         idle(50);
      end

      cur_req = "R10";
      for (int r = 0; r < 8; r++) begin
         wr(17, 36'($urandom_range(0, 3)));
         idle(int'($urandom_range(50, 300)));
         wr(16, 36'($urandom_range(0, 3)));
         idle(20);
      end

      cur_req = "R6";
      wr(8 + 3, 36'h0);
      wr(8 + 4, 36'd1);
      idle(100);

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #(150000 * 5);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog during %s: got timeout expected completion", cur_req);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule